// File: doc/BRIEF.md
# Multiplexed Parallel Slave Port

This block is the device end of a 16-bit parallel bus on which address and data share the same wires. The host selects the device with an active-high select line. It places a word address on the low 14 bus bits and pulses an address-latch strobe. It then pulses a read strobe, or one or both of two byte-lane write strobes. Every strobe and the select line are asynchronous to the device. Each one passes through a two-flop synchronizer clocked by the system clock, so every action follows the synchronized edges.

On the device side the block drives a simple synchronous memory port. That port has an address, write data, a two-bit byte enable, a single-cycle write pulse, a single-cycle read pulse, and read data that returns a fixed number of cycles after the read pulse. The bidirectional pad is modelled as three signals: an input, an output and an output enable. The host keeps the bus value stable while a strobe is high and for at least three clock periods after it falls. Each strobe stays high for at least three clock periods. Once an address is latched, any number of reads and writes may be repeated on it without a new address phase.

A write strobe that overlaps read or address latch while the device is selected is a protocol violation. The block raises a sticky error flag and drops that write.

Top module: `mpsp_slave`

## Requirements
- R1: After reset, mem_we_o, mem_re_o, err_o and bus_oe_o are 0, and bus_out_o is all zeros.
- R2: While selected, the address used for memory accesses is taken from bus bits 13:0 during an address-latch pulse. Bus bits 15:14 are ignored. The address does not change again until the next address-latch pulse.
- R3: bus_oe_o is 1 only while both cs_i and rd_i are 1. Whenever bus_oe_o is 0, bus_out_o is all zeros.
- R4: Each read pulse produces exactly one single-cycle mem_re_o. Within 6 clock cycles of rd_i rising, bus_out_o carries the full 16-bit word at the latched address.
- R5: A pulse on wrl_i alone produces one write with mem_be_o = 2'b01 (bit 0 enables bits 7:0). mem_wdata_o[7:0] carries the bus bits 7:0 presented during the pulse.
- R6: A pulse on wrh_i alone produces one write with mem_be_o = 2'b10 (bit 1 enables bits 15:8). mem_wdata_o[15:8] carries the bus bits 15:8 presented during the pulse.
- R7: Overlapping pulses on wrh_i and wrl_i, including pulses whose edges are skewed by a clock, produce a single write with mem_be_o = 2'b11.
- R8: Reads and writes repeated without a new address-latch pulse all use the most recently latched address.
- R9: A write strobe that is high together with rd_i or al_i while selected sets err_o. err_o stays 1 until reset, and that write never reaches memory.
- R10: While cs_i is 0, no address-latch, read or write strobe has any effect: no mem_we_o, no mem_re_o, and the latched address is unchanged.
- R11: A write commits on the synchronized falling edge of the write strobes as a mem_we_o pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Device select, active high, asynchronous |
| al_i | input | 1 | Address-latch strobe, active high |
| rd_i | input | 1 | Read strobe, active high |
| wrh_i | input | 1 | High byte-lane write strobe, active high |
| wrl_i | input | 1 | Low byte-lane write strobe, active high |
| bus_in_i | input | 16 | Shared address/data bus, pad input side |
| bus_out_o | output | 16 | Shared bus, pad output side |
| bus_oe_o | output | 1 | Pad output enable |
| mem_addr_o | output | 14 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_be_o | output | 2 | Memory byte enables |
| mem_we_o | output | 1 | Memory write pulse |
| mem_re_o | output | 1 | Memory read pulse |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after mem_re_o |
| err_o | output | 1 | Sticky strobe-overlap error flag |

## Verification
Writes are tried with the low strobe alone, the high strobe alone, and both strobes with a one-cycle skew. These cases show whether the lanes are decoded separately and whether skewed strobes merge into a single write. A read-back after a low-lane write, then a high-lane write, with no address phase in between, shows whether the address is reused and whether each lane was written without touching the other. An address phase with the upper bus bits set, a burst of strobes while deselected, and a write that overlaps a read complete the set. Each of these three shows whether the ignored input really left the address, the memory and the error flag alone.

// File: rtl/mpsp_pkg.sv
`timescale 1ns/1ps
package mpsp_pkg;
   localparam int NUM_STRB  = 5;
   localparam int NUM_LANES = 2;

   typedef struct packed {
      logic sel;
      logic alat;
      logic rdst;
      logic wr_hi;
      logic wr_lo;
   } mpsp_strb_t;

   typedef logic [NUM_LANES-1:0] mpsp_lane_t;
endpackage

// File: rtl/mpsp_sync.sv
`timescale 1ns/1ps
module mpsp_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mpsp_addr_latch.sv
`timescale 1ns/1ps
module mpsp_addr_latch #(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              alat_i,
   input  logic              blk_i,
   input  logic [BUS_W-1:0]  bus_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;
   logic              take;

   // address follows the bus only while a legal latch strobe is seen
   assign take = sel_i & alat_i & ~blk_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= bus_i[ADDR_W-1:0];
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/mpsp_wr_ctl.sv
`timescale 1ns/1ps
module mpsp_wr_ctl
   import mpsp_pkg::*;
#(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             wr_hi_i,
   input  logic             wr_lo_i,
   input  logic             conflict_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             we_o,
   output mpsp_lane_t       be_o,
   output logic [BUS_W-1:0] wdata_o,
   output logic             active_o,
   output logic             err_o
);
   logic             any_now, any_prev;
   logic             overlap;
   mpsp_lane_t       lanes_q;
   logic             poison_q;
   logic             err_q;
   logic [BUS_W-1:0] data_q;

   assign any_now = sel_i & (wr_hi_i | wr_lo_i);
   assign overlap = any_now & conflict_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_prev <= 1'b0;
         lanes_q  <= '0;
         poison_q <= 1'b0;
         err_q    <= 1'b0;
         data_q   <= '0;
      end else begin
         any_prev <= any_now;
         if (any_now) begin
            // lanes seen at any point of the pulse merge into one write
            lanes_q  <= lanes_q | {wr_hi_i, wr_lo_i};
            poison_q <= poison_q | overlap;
            data_q   <= bus_i;
         end else begin
            lanes_q  <= '0;
            poison_q <= 1'b0;
         end
         if (overlap) err_q <= 1'b1;
      end
   end

   // commit on the synchronized fall, only if still selected and clean
   assign we_o     = any_prev & ~any_now & sel_i & ~poison_q;
   assign be_o     = lanes_q;
   assign wdata_o  = data_q;
   assign active_o = any_now;
   assign err_o    = err_q;
endmodule

// File: rtl/mpsp_rd_ctl.sv
`timescale 1ns/1ps
module mpsp_rd_ctl #(
   parameter int BUS_W  = 16,
   parameter int RD_LAT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             rdst_i,
   input  logic             blk_i,
   input  logic             cs_pad_i,
   input  logic             rd_pad_i,
   input  logic [BUS_W-1:0] rdata_i,
   output logic             re_o,
   output logic [BUS_W-1:0] bus_o,
   output logic             oe_o
);
   logic              rd_prev;
   logic [RD_LAT-1:0] vld_q;
   logic [BUS_W-1:0]  hold_q;

   assign re_o = sel_i & rdst_i & ~rd_prev & ~blk_i;

   generate
      if (RD_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= re_o;
         end
      end else begin : g_lat_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= {vld_q[RD_LAT-2:0], re_o};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b0;
         hold_q  <= '0;
      end else begin
         rd_prev <= sel_i & rdst_i;
         if (vld_q[RD_LAT-1]) hold_q <= rdata_i;
      end
   end

   // the pad enable follows the raw pins so the bus is released at once
   assign oe_o  = cs_pad_i & rd_pad_i;
   assign bus_o = oe_o ? hold_q : '0;
endmodule

// File: rtl/mpsp_slave.sv
`timescale 1ns/1ps
module mpsp_slave
   import mpsp_pkg::*;
#(
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 14,
   parameter int SYNC_STAGES = 2,
   parameter int RD_LAT      = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              al_i,
   input  logic              rd_i,
   input  logic              wrh_i,
   input  logic              wrl_i,
   input  logic [BUS_W-1:0]  bus_in_i,
   output logic [BUS_W-1:0]  bus_out_o,
   output logic              bus_oe_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BUS_W-1:0]  mem_wdata_o,
   output logic [1:0]        mem_be_o,
   output logic              mem_we_o,
   output logic              mem_re_o,
   input  logic [BUS_W-1:0]  mem_rdata_i,
   output logic              err_o
);
   localparam int LANE_W = BUS_W / NUM_LANES;

   generate
      if (BUS_W % NUM_LANES != 0 || LANE_W < 1) begin : g_bad_bus
         $error("bus width must split into two equal lanes");
      end
      if (ADDR_W > BUS_W || ADDR_W < 1) begin : g_bad_addr
         $error("address must fit on the shared bus");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchronizer stages are needed");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("read latency must be at least one cycle");
      end
   endgenerate

   mpsp_strb_t raw_s, syn_s;
   mpsp_lane_t be_w;
   logic       wr_active;

   assign raw_s = '{sel: cs_i, alat: al_i, rdst: rd_i, wr_hi: wrh_i, wr_lo: wrl_i};

   mpsp_sync #(.WIDTH(NUM_STRB), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_s),
      .q_o   (syn_s)
   );

   mpsp_addr_latch #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) alat_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (syn_s.sel),
      .alat_i (syn_s.alat),
      .blk_i  (wr_active),
      .bus_i  (bus_in_i),
      .addr_o (mem_addr_o)
   );

   mpsp_wr_ctl #(.BUS_W(BUS_W)) wr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (syn_s.sel),
      .wr_hi_i    (syn_s.wr_hi),
      .wr_lo_i    (syn_s.wr_lo),
      .conflict_i (syn_s.rdst | syn_s.alat),
      .bus_i      (bus_in_i),
      .we_o       (mem_we_o),
      .be_o       (be_w),
      .wdata_o    (mem_wdata_o),
      .active_o   (wr_active),
      .err_o      (err_o)
   );

   assign mem_be_o = be_w;

   mpsp_rd_ctl #(.BUS_W(BUS_W), .RD_LAT(RD_LAT)) rd_i_u (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (syn_s.sel),
      .rdst_i   (syn_s.rdst),
      .blk_i    (wr_active),
      .cs_pad_i (cs_i),
      .rd_pad_i (rd_i),
      .rdata_i  (mem_rdata_i),
      .re_o     (mem_re_o),
      .bus_o    (bus_out_o),
      .oe_o     (bus_oe_o)
   );
endmodule

// File: rtl/mpsp_slave_chk.sv
`timescale 1ns/1ps
module mpsp_slave_chk #(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_i,
   input logic              al_i,
   input logic [BUS_W-1:0]  bus_out_o,
   input logic              bus_oe_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [1:0]        mem_be_o,
   input logic              mem_we_o,
   input logic              mem_re_o,
   input logic              err_o
);
   logic [2:0] al_quiet, cs_quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_quiet <= '0;
         cs_quiet <= '0;
      end else begin
         al_quiet <= al_i ? 3'd0 : ((al_quiet == 3'd7) ? al_quiet : al_quiet + 3'd1);
         cs_quiet <= cs_i ? 3'd0 : ((cs_quiet == 3'd7) ? cs_quiet : cs_quiet + 3'd1);
      end
   end

   assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);
   assert_re_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> !mem_re_o);
   assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_o |-> (bus_out_o == '0));
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   assert_be_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_be_o != 2'b00));
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (al_quiet >= 3'd3) |=> $stable(mem_addr_o));
   assert_idle_unselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_quiet >= 3'd3) |-> (!mem_we_o && !mem_re_o));
endmodule

bind mpsp_slave mpsp_slave_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mpsp_slave_tb.sv
`timescale 1ns/1ps
module mpsp_slave_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_i = 1'b0, al_i = 1'b0, rd_i = 1'b0, wrh_i = 1'b0, wrl_i = 1'b0;
   logic [15:0] bus_in_i = '0;
   logic [15:0] bus_out_o;
   logic        bus_oe_o;
   logic [13:0] mem_addr_o;
   logic [15:0] mem_wdata_o;
   logic [1:0]  mem_be_o;
   logic        mem_we_o, mem_re_o;
   logic [15:0] mem_rdata_i = '0;
   logic        err_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mpsp_slave dut_i (.*);

   // memory model and bench-side expected contents
   logic [15:0] mem     [64];
   logic [15:0] ref_mem [64];
   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]     = 16'hA500 + 16'(i * 3);
         ref_mem[i] = 16'hA500 + 16'(i * 3);
      end
   end

   always @(posedge clk) begin
      if (mem_we_o) begin
         if (mem_be_o[0]) mem[mem_addr_o[5:0]][7:0]  <= mem_wdata_o[7:0];
         if (mem_be_o[1]) mem[mem_addr_o[5:0]][15:8] <= mem_wdata_o[15:8];
      end
      if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[5:0]];
   end

   // observe the memory port away from the active edge
   int          we_cnt = 0, re_cnt = 0;
   logic [13:0] last_addr;
   logic [1:0]  last_be;
   logic [15:0] last_data;
   always @(negedge clk) begin
      if (mem_we_o) begin
         we_cnt++;
         last_addr = mem_addr_o;
         last_be   = mem_be_o;
         last_data = mem_wdata_o;
      end
      if (mem_re_o) re_cnt++;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic latch_addr(input logic [15:0] busval);
      bus_in_i = busval; al_i = 1'b1; cyc(4);
      al_i = 1'b0; cyc(4);
   endtask

   task automatic write_pulse(input bit hi, input bit lo, input logic [15:0] d, input bit skew);
      bus_in_i = d;
      if (skew) begin
         wrl_i = lo; cyc(1); wrh_i = hi; cyc(3); wrl_i = 1'b0; cyc(1); wrh_i = 1'b0;
      end else begin
         wrh_i = hi; wrl_i = lo; cyc(4); wrh_i = 1'b0; wrl_i = 1'b0;
      end
      cyc(5);
   endtask

   task automatic read_word(input logic [15:0] exp, input string req);
      int re0 = re_cnt;
      rd_i = 1'b1; cyc(6);
      check(bus_oe_o === 1'b1, "R3 oe while reading", 32'(bus_oe_o), 1);
      check(bus_out_o === exp, req, 32'(bus_out_o), 32'(exp));
      check(re_cnt == re0 + 1, "R4 one read pulse", 32'(re_cnt - re0), 1);
      rd_i = 1'b0; #1;
      check(bus_oe_o === 1'b0 && bus_out_o === 16'h0, "R3 released after read", 32'(bus_out_o), 0);
      cyc(4);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; cyc(3);
      check(!mem_we_o && !mem_re_o && !err_o, "R1 reset strobes", {29'd0, mem_we_o, mem_re_o, err_o}, 0);
      check(!bus_oe_o && bus_out_o == 16'h0, "R1 reset bus", 32'(bus_out_o), 0);
      rst_n = 1'b1; cs_i = 1'b1; cyc(3);
   endtask

   task automatic t_low_lane;
      int w0;
      latch_addr(16'hD234);
      w0 = we_cnt;
      write_pulse(1'b0, 1'b1, 16'h775A, 1'b0);
      ref_mem[6'h34][7:0] = 8'h5A;
      check(we_cnt == w0 + 1, "R11 one commit", 32'(we_cnt - w0), 1);
      check(last_addr == 14'h1234, "R2 upper bits ignored", 32'(last_addr), 32'h1234);
      check(last_be == 2'b01, "R5 low lane enable", 32'(last_be), 1);
      check(last_data[7:0] == 8'h5A, "R5 low lane data", 32'(last_data[7:0]), 32'h5A);
   endtask

   task automatic t_high_lane_reuse;
      int w0 = we_cnt;
      write_pulse(1'b1, 1'b0, 16'hC311, 1'b0);
      ref_mem[6'h34][15:8] = 8'hC3;
      check(we_cnt == w0 + 1, "R6 one commit", 32'(we_cnt - w0), 1);
      check(last_be == 2'b10, "R6 high lane enable", 32'(last_be), 2);
      check(last_data[15:8] == 8'hC3, "R6 high lane data", 32'(last_data[15:8]), 32'hC3);
      check(last_addr == 14'h1234, "R8 address reused", 32'(last_addr), 32'h1234);
      read_word(ref_mem[6'h34], "R8 R4 merged word read back");
   endtask

   task automatic t_both_skewed;
      int w0;
      latch_addr(16'h0007);
      w0 = we_cnt;
      write_pulse(1'b1, 1'b1, 16'hBEEF, 1'b1);
      ref_mem[6'h07] = 16'hBEEF;
      check(we_cnt == w0 + 1, "R7 single merged write", 32'(we_cnt - w0), 1);
      check(last_be == 2'b11, "R7 both lanes", 32'(last_be), 3);
      read_word(ref_mem[6'h07], "R4 full word read");
      read_word(ref_mem[6'h07], "R8 repeated read");
   endtask

   task automatic t_deselected;
      int w0 = we_cnt;
      int r0 = re_cnt;
      cs_i = 1'b0; cyc(2);
      latch_addr(16'h0020);
      write_pulse(1'b0, 1'b1, 16'h0099, 1'b0);
      rd_i = 1'b1; cyc(5);
      check(bus_oe_o === 1'b0, "R3 no drive when deselected", 32'(bus_oe_o), 0);
      rd_i = 1'b0; cyc(4);
      check(we_cnt == w0 && re_cnt == r0, "R10 no access when deselected", 32'(we_cnt - w0 + re_cnt - r0), 0);
      cs_i = 1'b1; cyc(4);
      read_word(ref_mem[6'h07], "R10 address kept while deselected");
   endtask

   task automatic t_overlap;
      int w0;
      latch_addr(16'h0011);
      w0 = we_cnt;
      bus_in_i = 16'h1234; rd_i = 1'b1; wrl_i = 1'b1; cyc(4);
      rd_i = 1'b0; wrl_i = 1'b0; cyc(6);
      check(err_o === 1'b1, "R9 error flagged", 32'(err_o), 1);
      check(we_cnt == w0, "R9 write suppressed", 32'(we_cnt - w0), 0);
      read_word(ref_mem[6'h11], "R9 memory unchanged");
      check(err_o === 1'b1, "R9 error sticky", 32'(err_o), 1);
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      cyc(1);
      t_reset();
      t_low_lane();
      t_high_lane_reuse();
      t_both_skewed();
      t_deselected();
      t_overlap();
      cyc(5);
      finish_run();
   end

   initial begin
      #500000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end
endmodule